// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator with Dead Time

This block drives the six gate signals of a three-phase motor inverter. An up/down counter sets the switching period. Each of the three phase legs compares the counter with its own duty setting and makes a complementary high-side/low-side pair, centred on the period midpoint. Every edge is moved inward by a programmable dead time. Software-style settings arrive through plain write ports: period, dead time, minimum pulse, three duty counts, a chopping divider and a mode word. Settings take effect only at defined points in the period, so a new value never tears a pulse in progress.

The timebase is a state machine with three states. `TB_IDLE` is held while the period setting is zero. The transition *start* goes to `TB_UP` and loads every shadow register. `TB_UP` counts from 0 up to period−1. The transition *apex* then enters `TB_DOWN`, and in double-update mode the duty shadows reload here. `TB_DOWN` counts back to 0. The transition *wrap* re-enters `TB_UP` and reloads all shadows, or the transition *halt* returns to `TB_IDLE` if the period setting is zero. A one-clock sync pulse marks the first count-up cycle of each period.

A separate protection state has two states, `ARMED` and `TRIPPED`. A falling edge on the active-low trip input enters `TRIPPED` asynchronously and forces all six gates to their off level at once. Only a clear strobe, given while the trip input is high, returns it to `ARMED`.

Top module: `pwm3_gen`

## Requirements
- R1: With period setting P > 0 the period lasts 2·P clocks. `sync_pulse` is high for exactly one clock at the start of each period. With P = 0 the block stays idle with every gate off and no sync pulse.
- R2: With dead time T and duty D, where 0 < D < P, the high side is on for 2·(D−T) clocks per period, floored at 0. The low side is on for 2·(P−D−T) clocks per period, floored at 0.
- R3: The high and low gate of any pair are never on in the same clock.
- R4: D = 0 keeps the low side on for the whole period and the high side off. D ≥ P keeps the high side on for the whole period and the low side off. Dead time is not applied in either case.
- R5: When a computed half-period on-time is non-zero but below the minimum-pulse setting, that side is off for the whole half period.
- R6: Mode bits 1, 2 and 3 enable crossover for pairs A, B and C. Crossover swaps the pair's high and low gate signals.
- R7: With chopping divider G, the chopping clock spends 2·(G+1) clocks in each phase. Mode bit 4 gates the high sides with it and mode bit 5 gates the low sides. Each bit acts alone.
- R8: Duty writes take effect only at the next period start. With mode bit 0 set they also take effect at the period midpoint.
- R9: With `pol_hi` = 0 a gate pin is low when on and high when off. With `pol_hi` = 1 all six pins are inverted.
- R10: A falling edge on `trip_n` turns all gates off immediately, without waiting for a clock. They stay off after `trip_n` returns high, until `trip_clr` is pulsed.
- R11: `duty_sel` values 0, 1 and 2 address pairs A, B and C. The value 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_wr | input | 1 | Write strobe for the period setting |
| per_din | input | CW | Period in clocks per half period |
| dead_wr | input | 1 | Write strobe for the dead time |
| dead_din | input | DTW | Dead time in clocks |
| minpw_wr | input | 1 | Write strobe for the minimum pulse |
| minpw_din | input | DTW | Minimum pulse width in clocks |
| duty_wr | input | 1 | Write strobe for a duty setting |
| duty_sel | input | 2 | Pair select: 0 A, 1 B, 2 C |
| duty_din | input | CW | Duty count |
| chop_wr | input | 1 | Write strobe for the chopping divider |
| chop_din | input | GW | Chopping divider G |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_din | input | 6 | Bit0 double update, bits1-3 crossover A/B/C, bit4 high chop, bit5 low chop |
| pol_hi | input | 1 | Static output polarity select |
| trip_n | input | 1 | Active-low asynchronous shutdown |
| trip_clr | input | 1 | Re-arm after a shutdown |
| gate_ah | output | 1 | Phase A high-side gate |
| gate_al | output | 1 | Phase A low-side gate |
| gate_bh | output | 1 | Phase B high-side gate |
| gate_bl | output | 1 | Phase B low-side gate |
| gate_ch | output | 1 | Phase C high-side gate |
| gate_cl | output | 1 | Phase C low-side gate |
| sync_pulse | output | 1 | One-clock start-of-period marker |

## Verification
The assertions assume the reset is applied before any write and that `trip_n` is high while reset is released. They also assume `pol_hi` changes only while the gates are idle or tripped, because the off-level check compares against its current value. The stimulus writes the settings only at falling clock edges. It changes `pol_hi` only between measurement windows, and it drops `trip_n` between edges, at least a clock after reset. Duty values chosen to exercise shoot-through protection include the saturating and minimum-pulse cases, so the no-overlap property is tested where the arithmetic floors to zero.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;
    localparam int NPAIR = 3;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_UP   = 2'd1,
        TB_DOWN = 2'd2
    } tb_state_e;

    typedef enum logic {
        PR_ARMED   = 1'b0,
        PR_TRIPPED = 1'b1
    } prot_state_e;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import pwm3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DTW = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CW-1:0]               per_live,
    input  logic [DTW-1:0]              dead_live,
    input  logic [DTW-1:0]              minpw_live,
    input  logic [NPAIR-1:0][CW-1:0]    duty_live,
    input  logic                        dbl_upd,
    output logic [CW-1:0]               cnt,
    output logic                        run,
    output logic                        sync,
    output logic [CW-1:0]               per_s,
    output logic [DTW-1:0]              dead_s,
    output logic [DTW-1:0]              minpw_s,
    output logic [NPAIR-1:0][CW-1:0]    duty_s
);
    tb_state_e     st, st_nxt;
    logic [CW-1:0] cnt_nxt;
    logic          ld_all, ld_mid;

    // next-state and counter logic
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        ld_all  = 1'b0;
        ld_mid  = 1'b0;
        unique case (st)
            TB_IDLE: begin
                if (per_live != '0) begin
                    st_nxt  = TB_UP;
                    cnt_nxt = '0;
                    ld_all  = 1'b1;
                end
            end
            TB_UP: begin
                if (cnt == per_s - 1'b1) begin
                    st_nxt = TB_DOWN;
                    ld_mid = dbl_upd;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            TB_DOWN: begin
                if (cnt == '0) begin
                    if (per_live == '0) begin
                        st_nxt = TB_IDLE;
                    end else begin
                        st_nxt = TB_UP;
                        ld_all = 1'b1;
                    end
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            default: st_nxt = TB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TB_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    // shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_s   <= '0;
            dead_s  <= '0;
            minpw_s <= '0;
            duty_s  <= '0;
        end else if (ld_all) begin
            per_s   <= per_live;
            dead_s  <= dead_live;
            minpw_s <= minpw_live;
            duty_s  <= duty_live;
        end else if (ld_mid) begin
            duty_s  <= duty_live;
        end
    end

    // outputs
    always_comb begin
        run  = (st != TB_IDLE);
        sync = (st == TB_UP) && (cnt == '0);
    end

    // R1
    sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> !sync);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < per_s));
endmodule

// File: rtl/pwm_chop.sv
`timescale 1ns/1ps
module pwm_chop #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] div_live,
    output logic          chop_ck
);
    localparam int DCW = GW + 1;

    logic [DCW-1:0] div_cnt;
    logic [DCW-1:0] lim;

    always_comb lim = {div_live, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            chop_ck <= 1'b0;
        end else if (div_cnt >= lim) begin
            div_cnt <= '0;
            chop_ck <= ~chop_ck;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R7
    chop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt < lim) |=> $stable(chop_ck));
endmodule

// File: rtl/pwm_pair.sv
`timescale 1ns/1ps
module pwm_pair #(
    parameter int CW  = 16,
    parameter int DTW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  cnt,
    input  logic           run,
    input  logic [CW-1:0]  per_s,
    input  logic [CW-1:0]  duty_s,
    input  logic [DTW-1:0] dead_s,
    input  logic [DTW-1:0] minpw_s,
    input  logic           xover,
    input  logic           chop_ck,
    input  logic           chop_hi_en,
    input  logic           chop_lo_en,
    output logic           on_hi,
    output logic           on_lo
);
    localparam int XW = CW + 1;

    logic [XW-1:0] p, d, dt, mp, c, hw, lw;
    logic          id_hi, id_lo, sw_hi, sw_lo;

    // half-period on-widths
    always_comb begin
        p  = {1'b0, per_s};
        d  = {1'b0, duty_s};
        c  = {1'b0, cnt};
        dt = {{(XW-DTW){1'b0}}, dead_s};
        mp = {{(XW-DTW){1'b0}}, minpw_s};
        if (d == '0) begin
            hw = '0;
            lw = p;
        end else if (d >= p) begin
            hw = p;
            lw = '0;
        end else begin
            hw = (d > dt) ? (d - dt) : '0;
            lw = (p > d + dt) ? (p - d - dt) : '0;
            if (hw != '0 && hw < mp) hw = '0;
            if (lw != '0 && lw < mp) lw = '0;
        end
    end

    // compare, crossover, chopping
    always_comb begin
        id_hi = run && (c + hw >= p);
        id_lo = run && (c < lw);
        sw_hi = xover ? id_lo : id_hi;
        sw_lo = xover ? id_hi : id_lo;
        on_hi = sw_hi && (!chop_hi_en || chop_ck);
        on_lo = sw_lo && (!chop_lo_en || chop_ck);
    end

    // R3
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(on_hi && on_lo));
endmodule

// File: rtl/pwm3_gen.sv
`timescale 1ns/1ps
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DTW = 10,
    parameter int GW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           per_wr,
    input  logic [CW-1:0]  per_din,
    input  logic           dead_wr,
    input  logic [DTW-1:0] dead_din,
    input  logic           minpw_wr,
    input  logic [DTW-1:0] minpw_din,
    input  logic           duty_wr,
    input  logic [1:0]     duty_sel,
    input  logic [CW-1:0]  duty_din,
    input  logic           chop_wr,
    input  logic [GW-1:0]  chop_din,
    input  logic           mode_wr,
    input  logic [5:0]     mode_din,
    input  logic           pol_hi,
    input  logic           trip_n,
    input  logic           trip_clr,
    output logic           gate_ah,
    output logic           gate_al,
    output logic           gate_bh,
    output logic           gate_bl,
    output logic           gate_ch,
    output logic           gate_cl,
    output logic           sync_pulse
);
    localparam int NG = 2 * NPAIR;

    logic [CW-1:0]            per_r;
    logic [DTW-1:0]           dead_r, minpw_r;
    logic [NPAIR-1:0][CW-1:0] duty_r;
    logic [GW-1:0]            chop_r;
    logic [5:0]               mode_r;

    logic [CW-1:0]            cnt, per_s;
    logic [DTW-1:0]           dead_s, minpw_s;
    logic [NPAIR-1:0][CW-1:0] duty_s;
    logic                     run, chop_ck;
    logic [NPAIR-1:0]         on_hi, on_lo;
    logic [NG-1:0]            g_on, g_pin;
    logic                     gates_off;
    prot_state_e              prot;

    // live setting registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_r   <= '0;
            dead_r  <= '0;
            minpw_r <= '0;
            duty_r  <= '0;
            chop_r  <= '0;
            mode_r  <= '0;
        end else begin
            if (per_wr)   per_r   <= per_din;
            if (dead_wr)  dead_r  <= dead_din;
            if (minpw_wr) minpw_r <= minpw_din;
            if (chop_wr)  chop_r  <= chop_din;
            if (mode_wr)  mode_r  <= mode_din;
            // R11: select 3 addresses nothing
            if (duty_wr && (32'(duty_sel) < NPAIR))
                duty_r[duty_sel] <= duty_din;
        end
    end

    // protection state: asynchronous entry, synchronous exit
    always_ff @(posedge clk or negedge rst_n or negedge trip_n) begin
        if (!rst_n) begin
            prot <= PR_ARMED;
        end else if (!trip_n) begin
            prot <= PR_TRIPPED;
        end else begin
            unique case (prot)
                PR_ARMED:   prot <= PR_ARMED;
                PR_TRIPPED: if (trip_clr) prot <= PR_ARMED;
                default:    prot <= PR_TRIPPED;
            endcase
        end
    end

    pwm_timebase #(.CW(CW), .DTW(DTW)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_live   (per_r),
        .dead_live  (dead_r),
        .minpw_live (minpw_r),
        .duty_live  (duty_r),
        .dbl_upd    (mode_r[0]),
        .cnt        (cnt),
        .run        (run),
        .sync       (sync_pulse),
        .per_s      (per_s),
        .dead_s     (dead_s),
        .minpw_s    (minpw_s),
        .duty_s     (duty_s)
    );

    pwm_chop #(.GW(GW)) u_chop (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_live (chop_r),
        .chop_ck  (chop_ck)
    );

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        pwm_pair #(.CW(CW), .DTW(DTW)) u_pair (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt        (cnt),
            .run        (run),
            .per_s      (per_s),
            .duty_s     (duty_s[k]),
            .dead_s     (dead_s),
            .minpw_s    (minpw_s),
            .xover      (mode_r[1+k]),
            .chop_ck    (chop_ck),
            .chop_hi_en (mode_r[4]),
            .chop_lo_en (mode_r[5]),
            .on_hi      (on_hi[k]),
            .on_lo      (on_lo[k])
        );
        always_comb begin
            g_on[2*k+1] = on_hi[k];
            g_on[2*k]   = on_lo[k];
        end
    end

    // output stage: trip blanking, then polarity
    always_comb begin
        gates_off = !trip_n || (prot == PR_TRIPPED);
        g_pin     = gates_off ? {NG{~pol_hi}} : (pol_hi ? g_on : ~g_on);
        gate_al   = g_pin[0];
        gate_ah   = g_pin[1];
        gate_bl   = g_pin[2];
        gate_bh   = g_pin[3];
        gate_cl   = g_pin[4];
        gate_ch   = g_pin[5];
    end

    // R10
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot == PR_TRIPPED) |->
        ({gate_ah, gate_al, gate_bh, gate_bl, gate_ch, gate_cl} == {NG{~pol_hi}}));

    // R1
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!sync_pulse && (g_on == '0)));
endmodule

// File: tb/pwm3_gen_bench.sv
`timescale 1ns/1ps
module pwm3_gen_bench;
    localparam int CW = 16, DTW = 10, GW = 8;
    localparam int PER = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic per_wr = 0, dead_wr = 0, minpw_wr = 0, duty_wr = 0, chop_wr = 0, mode_wr = 0;
    logic [CW-1:0]  per_din = '0, duty_din = '0;
    logic [DTW-1:0] dead_din = '0, minpw_din = '0;
    logic [1:0]     duty_sel = '0;
    logic [GW-1:0]  chop_din = '0;
    logic [5:0]     mode_din = '0;
    logic pol_hi = 1'b0, trip_n = 1'b1, trip_clr = 1'b0;
    logic gate_ah, gate_al, gate_bh, gate_bl, gate_ch, gate_cl, sync_pulse;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    int m_hi [3];
    int m_lo [3];
    int m_both, m_sync;
    logic m_next;

    always #2 clk = ~clk;

    pwm3_gen #(.CW(CW), .DTW(DTW), .GW(GW)) u_pwm3_gen (
        .clk(clk), .rst_n(rst_n),
        .per_wr(per_wr), .per_din(per_din),
        .dead_wr(dead_wr), .dead_din(dead_din),
        .minpw_wr(minpw_wr), .minpw_din(minpw_din),
        .duty_wr(duty_wr), .duty_sel(duty_sel), .duty_din(duty_din),
        .chop_wr(chop_wr), .chop_din(chop_din),
        .mode_wr(mode_wr), .mode_din(mode_din),
        .pol_hi(pol_hi), .trip_n(trip_n), .trip_clr(trip_clr),
        .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh),
        .gate_bl(gate_bl), .gate_ch(gate_ch), .gate_cl(gate_cl),
        .sync_pulse(sync_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic hi_pin(input int k);
        case (k)
            0: return gate_ah;
            1: return gate_bh;
            default: return gate_ch;
        endcase
    endfunction

    function automatic logic lo_pin(input int k);
        case (k)
            0: return gate_al;
            1: return gate_bl;
            default: return gate_cl;
        endcase
    endfunction

    task automatic wr_per(input int v);
        @(negedge clk); per_din = CW'(v); per_wr = 1; @(negedge clk); per_wr = 0;
    endtask
    task automatic wr_dead(input int v);
        @(negedge clk); dead_din = DTW'(v); dead_wr = 1; @(negedge clk); dead_wr = 0;
    endtask
    task automatic wr_min(input int v);
        @(negedge clk); minpw_din = DTW'(v); minpw_wr = 1; @(negedge clk); minpw_wr = 0;
    endtask
    task automatic wr_duty(input int s, input int v);
        @(negedge clk); duty_sel = 2'(s); duty_din = CW'(v); duty_wr = 1;
        @(negedge clk); duty_wr = 0;
    endtask
    task automatic wr_chop(input int v);
        @(negedge clk); chop_din = GW'(v); chop_wr = 1; @(negedge clk); chop_wr = 0;
    endtask
    task automatic wr_mode(input int v);
        @(negedge clk); mode_din = 6'(v); mode_wr = 1; @(negedge clk); mode_wr = 0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (sync_pulse !== 1'b1);
    endtask

    task automatic acc();
        for (int k = 0; k < 3; k++) begin
            if (hi_pin(k) == pol_hi) m_hi[k]++;
            if (lo_pin(k) == pol_hi) m_lo[k]++;
            if (hi_pin(k) == pol_hi && lo_pin(k) == pol_hi) m_both++;
        end
        if (sync_pulse) m_sync++;
    endtask

    task automatic clr_m();
        for (int k = 0; k < 3; k++) begin m_hi[k] = 0; m_lo[k] = 0; end
        m_both = 0; m_sync = 0;
    endtask

    // one full period, starting in the sync cycle
    task automatic measure();
        clr_m();
        wait_sync();
        for (int i = 0; i < 2*PER; i++) begin
            if (i > 0) @(negedge clk);
            acc();
        end
        @(negedge clk);
        m_next = sync_pulse;
    endtask

    task automatic run_len(input int k, input bit lo_side, output int n);
        n = 0;
        while (((lo_side ? lo_pin(k) : hi_pin(k)) == pol_hi)) @(negedge clk);
        while (((lo_side ? lo_pin(k) : hi_pin(k)) != pol_hi)) @(negedge clk);
        while (((lo_side ? lo_pin(k) : hi_pin(k)) == pol_hi)) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        int bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if ({gate_ah, gate_al, gate_bh, gate_bl, gate_ch, gate_cl} != 6'h3f || sync_pulse) bad++;
        end
        chk("R1 idle gates off, no sync", bad, 0);
    endtask

    task automatic t_basic();
        wr_dead(2); wr_min(0);
        wr_duty(0, 8); wr_duty(1, 0); wr_duty(2, 25);
        wr_mode(0); wr_per(PER);
        measure();
        chk("R1 single sync per period", m_sync, 1);
        chk("R1 next period after 2P", int'(m_next), 1);
        chk("R2 A high on-time", m_hi[0], 12);
        chk("R2 A low on-time", m_lo[0], 20);
        chk("R3 no overlap", m_both, 0);
        chk("R4 full-off high", m_hi[1], 0);
        chk("R4 full-off low", m_lo[1], 40);
        chk("R4 full-on high", m_hi[2], 40);
        chk("R4 full-on low", m_lo[2], 0);
    endtask

    task automatic t_dead();
        wr_dead(4);
        measure();
        chk("R2 A high dead4", m_hi[0], 8);
        chk("R2 A low dead4", m_lo[0], 16);
        chk("R4 full-off low ignores dead", m_lo[1], 40);
        wr_dead(2);
    endtask

    task automatic t_minpw();
        wr_min(4); wr_duty(0, 5); wr_duty(1, 16);
        measure();
        chk("R5 short high removed", m_hi[0], 0);
        chk("R5 A low kept", m_lo[0], 26);
        chk("R5 B high kept", m_hi[1], 28);
        chk("R5 short low removed", m_lo[1], 0);
        chk("R3 no overlap min", m_both, 0);
        wr_min(0); wr_duty(0, 8); wr_duty(1, 0);
    endtask

    task automatic t_sel();
        wr_duty(3, 3);
        measure();
        chk("R11 sel 3 leaves A", m_hi[0], 12);
        chk("R11 sel 3 leaves B", m_lo[1], 40);
        chk("R11 sel 3 leaves C", m_hi[2], 40);
    endtask

    task automatic t_xover();
        wr_mode(6'b000010);
        measure();
        chk("R6 A high pin carries low", m_hi[0], 20);
        chk("R6 A low pin carries high", m_lo[0], 12);
        chk("R6 B not swapped", m_lo[1], 40);
        wr_mode(0);
    endtask

    task automatic upd_run(input bit dbl, input int exp, input string tag);
        wr_duty(0, 8);
        wr_mode(dbl ? 1 : 0);
        measure();
        clr_m();
        wait_sync();
        for (int i = 0; i < 2*PER; i++) begin
            if (i > 0) @(negedge clk);
            acc();
            if (i == 3) begin duty_sel = 2'd0; duty_din = CW'(12); duty_wr = 1; end
            if (i == 4) duty_wr = 0;
        end
        chk(tag, m_hi[0], exp);
    endtask

    task automatic t_update();
        upd_run(1'b0, 12, "R8 single update holds");
        upd_run(1'b1, 16, "R8 double update midpoint");
        measure();
        chk("R8 double full period", m_hi[0], 20);
        wr_mode(0); wr_duty(0, 8);
    endtask

    task automatic t_chop();
        int n;
        wr_chop(2);
        wr_mode(6'b100000);
        measure();
        chk("R7 high not chopped by low bit", m_hi[2], 40);
        run_len(1, 1'b1, n);
        chk("R7 low chop run", n, 6);
        wr_mode(6'b010000);
        measure();
        chk("R7 low not chopped by high bit", m_lo[1], 40);
        run_len(2, 1'b0, n);
        chk("R7 high chop run", n, 6);
        wr_chop(0);
        run_len(2, 1'b0, n);
        chk("R7 high chop run G0", n, 2);
        wr_mode(0);
    endtask

    task automatic t_pol();
        int cnt1 = 0;
        @(negedge clk); pol_hi = 1'b1;
        wait_sync();
        for (int i = 0; i < 2*PER; i++) begin
            if (i > 0) @(negedge clk);
            if (gate_ah == 1'b1) cnt1++;
        end
        chk("R9 inverted high count", cnt1, 12);
        @(negedge clk); #1 trip_n = 1'b0; #0.5;
        chk("R9 off level inverted", int'({gate_ah, gate_al, gate_bh, gate_bl, gate_ch, gate_cl}), 0);
        @(negedge clk); trip_n = 1'b1; pol_hi = 1'b0;
        @(negedge clk); trip_clr = 1'b1; @(negedge clk); trip_clr = 1'b0;
    endtask

    task automatic t_trip();
        int bad = 0;
        wait_sync();
        @(negedge clk);
        chk("R10 C high on before trip", int'(gate_ch), 0);
        #1 trip_n = 1'b0;
        #0.5;
        chk("R10 immediate off", int'({gate_ah, gate_al, gate_bh, gate_bl, gate_ch, gate_cl}), 63);
        @(negedge clk); trip_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if ({gate_ah, gate_al, gate_bh, gate_bl, gate_ch, gate_cl} != 6'h3f) bad++;
        end
        chk("R10 stays off after release", bad, 0);
        @(negedge clk); trip_clr = 1'b1; @(negedge clk); trip_clr = 1'b0;
        measure();
        chk("R10 resumes C", m_hi[2], 40);
        chk("R10 resumes A", m_hi[0], 12);
    endtask

    task automatic t_halt();
        int bad = 0;
        wr_per(0);
        repeat (2*PER + 2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if ({gate_ah, gate_al, gate_bh, gate_bl, gate_ch, gate_cl} != 6'h3f || sync_pulse) bad++;
        end
        chk("R1 halt to idle", bad, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_dead();
        t_minpw();
        t_sel();
        t_xover();
        t_update();
        t_chop();
        t_pol();
        t_trip();
        t_halt();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule